// File: doc/BRIEF.md
# Programmable Synthesizer Ratio Dividers

This block holds the two digital counters of a frequency synthesizer loop. The reference counter divides a reference clock, and the feedback counter divides the oscillator clock. Each counter runs on its own clock and emits a one-cycle pulse for a phase comparator. The comparator, oscillator, loop filter and output stage sit outside the block. The block also reports the ratio it is applying, as a numerator and a denominator. The loop settles at an output frequency equal to the reference frequency times numerator over denominator.

Two modes set the ratio. In programmed mode, the feedback length is twice the sum of the feedback code and three. The reference length is the reference code plus two, unless a bypass bit forces it to one. In pin mode, both codes and the bypass bit are ignored, and a select pin chooses a fixed multiplier with a denominator of one. The select pin is pulled high at board level, so an unconnected pin gives the lower multiplier.

The configuration inputs are plain, quasi-static control pins; there is no streaming data path and so no valid/ready handshake. A counter takes up a new length only at its terminal count, so a ratio change never produces a shortened period.

Top module: `pll_ratio_div`

## Requirements
- R1: With prog_sel=1, ratio_num equals (fb_code+3)*2, an even value from 6 to 516.
- R2: With prog_sel=1 and ref_bypass=0, ratio_den equals ref_code+2, from 2 to 65.
- R3: With prog_sel=1 and ref_bypass=1, ratio_den is 1 whatever ref_code holds.
- R4: With prog_sel=0, fb_code, ref_code and ref_bypass have no effect; ratio_num is 16 when mult_sel=0 and 8 when mult_sel=1, and ratio_den is 1.
- R5: fb_pulse is high for one fb_clk cycle once every ratio_num fb_clk cycles, and ref_pulse is high for one ref_clk cycle once every ratio_den ref_clk cycles.
- R6: A new length takes effect only at the next terminal count: the period in progress when the ratio changes completes with its old length.
- R7: With a length of 1, the counter's pulse stays high on every cycle of its clock.
- R8: While rst_n is low both pulses are low; after release, the first pulse appears after the (N+1)-th rising edge of that counter's clock, with N the length of that counter.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ref_clk | input | 1 | Reference clock, drives the reference counter |
| fb_clk | input | 1 | Oscillator clock, drives the feedback counter |
| rst_n | input | 1 | Asynchronous active-low reset for both counters |
| fb_code | input | 8 | Programmed feedback code |
| ref_code | input | 6 | Programmed reference code |
| prog_sel | input | 1 | 1 = programmed codes, 0 = pin-selected multiplier |
| ref_bypass | input | 1 | 1 = reference length forced to 1 in programmed mode |
| mult_sel | input | 1 | Pin-mode multiplier: 0 = x16, 1 = x8 |
| ref_pulse | output | 1 | One-cycle pulse every ratio_den ref_clk cycles |
| fb_pulse | output | 1 | One-cycle pulse every ratio_num fb_clk cycles |
| ratio_num | output | 10 | Feedback length currently selected |
| ratio_den | output | 7 | Reference length currently selected |

## Verification
The bench builds the block with its default parameters: an 8-bit feedback code, a 6-bit reference code, offsets of 3 and 2, a scale of 2, and pin multipliers of 16 and 8. With these values the full code range is reachable in simulation. This covers the extreme feedback length of 516, the extreme reference length of 65 and the minimum even length of 6. The reference length of 1 is reached in both modes, so the continuous-pulse case and the mid-period ratio change are exercised on real counter lengths.

// File: rtl/pll_ratio_pkg.sv
package pll_ratio_pkg;
  typedef enum logic {
    MODE_PIN  = 1'b0,
    MODE_PROG = 1'b1
  } ratio_mode_e;

  function automatic int unsigned len_width(input int unsigned max_len);
    return $clog2(max_len + 1);
  endfunction
endpackage

// File: rtl/pll_ratio_decode.sv
module pll_ratio_decode
  import pll_ratio_pkg::*;
#(
  parameter int unsigned FB_CODE_W  = 8,
  parameter int unsigned REF_CODE_W = 6,
  parameter int unsigned FB_OFFSET  = 3,
  parameter int unsigned FB_SCALE   = 2,
  parameter int unsigned REF_OFFSET = 2,
  parameter int unsigned PIN_MULT_0 = 16,
  parameter int unsigned PIN_MULT_1 = 8,
  parameter int unsigned NUM_W      = 10,
  parameter int unsigned DEN_W      = 7
) (
  input  logic [FB_CODE_W-1:0]  fb_code,
  input  logic [REF_CODE_W-1:0] ref_code,
  input  ratio_mode_e           mode,
  input  logic                  ref_bypass,
  input  logic                  mult_sel,
  output logic [NUM_W-1:0]      num_o,
  output logic [DEN_W-1:0]      den_o
);
  localparam int unsigned DEN_MAX = (2**REF_CODE_W - 1) + REF_OFFSET;

  logic [NUM_W-1:0] prog_num;
  logic [DEN_W-1:0] prog_den;
  logic [NUM_W-1:0] pin_num;

  always_comb begin
    prog_num = (NUM_W'(fb_code) + NUM_W'(FB_OFFSET)) * NUM_W'(FB_SCALE);
    prog_den = ref_bypass ? DEN_W'(1) : (DEN_W'(ref_code) + DEN_W'(REF_OFFSET));
    pin_num  = mult_sel ? NUM_W'(PIN_MULT_1) : NUM_W'(PIN_MULT_0);
    if (mode == MODE_PROG) begin
      num_o = prog_num;
      den_o = prog_den;
    end else begin
      num_o = pin_num;
      den_o = DEN_W'(1);
    end
  end

  always_comb begin
    if (!$isunknown({mode, ref_bypass, fb_code, ref_code, mult_sel})) begin
      AST_NUM_EVEN: assert (mode != MODE_PROG || FB_SCALE % 2 != 0 || num_o[0] == 1'b0); // R1
      AST_DEN_RANGE: assert (den_o >= 1 && int'(den_o) <= DEN_MAX); // R2
      AST_BYPASS_ONE: assert (!(mode == MODE_PROG && ref_bypass) || den_o == 1); // R3
      AST_PIN_DEN: assert (mode == MODE_PROG || den_o == 1); // R4
    end
  end
endmodule

// File: rtl/pll_div_counter.sv
module pll_div_counter #(
  parameter int unsigned LEN_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LEN_W-1:0] len_i,
  output logic             pulse_o
);
  logic [LEN_W-1:0] cnt_q;
  logic [LEN_W-1:0] cur_len_q;
  logic             pulse_q;
  logic             at_tc;
  logic             idle;

  assign at_tc   = (cnt_q == LEN_W'(1));
  assign idle    = (cnt_q == '0);
  assign pulse_o = pulse_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      cur_len_q <= '0;
      pulse_q   <= 1'b0;
    end else begin
      pulse_q <= at_tc;
      if (at_tc || idle) begin
        cnt_q     <= len_i;
        cur_len_q <= len_i;
      end else begin
        cnt_q <= cnt_q - LEN_W'(1);
      end
    end
  end

  AST_LEN_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    len_i != '0); // R5
  AST_NO_RUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q > LEN_W'(1)) |=> $stable(cur_len_q)); // R6
  AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_q && cur_len_q > LEN_W'(1)) |=> !pulse_q); // R5
  AST_DIV1_CONT: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_q && cur_len_q == LEN_W'(1)) |=> pulse_q); // R7
endmodule

// File: rtl/pll_ratio_div.sv
module pll_ratio_div
  import pll_ratio_pkg::*;
#(
  parameter int unsigned FB_CODE_W  = 8,
  parameter int unsigned REF_CODE_W = 6,
  parameter int unsigned FB_OFFSET  = 3,
  parameter int unsigned FB_SCALE   = 2,
  parameter int unsigned REF_OFFSET = 2,
  parameter int unsigned PIN_MULT_0 = 16,
  parameter int unsigned PIN_MULT_1 = 8,
  localparam int unsigned NUM_MAX   = ((2**FB_CODE_W - 1) + FB_OFFSET) * FB_SCALE,
  localparam int unsigned DEN_MAX   = (2**REF_CODE_W - 1) + REF_OFFSET,
  localparam int unsigned NUM_W     = len_width(NUM_MAX),
  localparam int unsigned DEN_W     = len_width(DEN_MAX)
) (
  input  logic                  ref_clk,
  input  logic                  fb_clk,
  input  logic                  rst_n,
  input  logic [FB_CODE_W-1:0]  fb_code,
  input  logic [REF_CODE_W-1:0] ref_code,
  input  logic                  prog_sel,
  input  logic                  ref_bypass,
  input  logic                  mult_sel,
  output logic                  ref_pulse,
  output logic                  fb_pulse,
  output logic [NUM_W-1:0]      ratio_num,
  output logic [DEN_W-1:0]      ratio_den
);
  ratio_mode_e mode;
  assign mode = prog_sel ? MODE_PROG : MODE_PIN;

  pll_ratio_decode #(
    .FB_CODE_W (FB_CODE_W),
    .REF_CODE_W(REF_CODE_W),
    .FB_OFFSET (FB_OFFSET),
    .FB_SCALE  (FB_SCALE),
    .REF_OFFSET(REF_OFFSET),
    .PIN_MULT_0(PIN_MULT_0),
    .PIN_MULT_1(PIN_MULT_1),
    .NUM_W     (NUM_W),
    .DEN_W     (DEN_W)
  ) u_decode (
    .fb_code   (fb_code),
    .ref_code  (ref_code),
    .mode      (mode),
    .ref_bypass(ref_bypass),
    .mult_sel  (mult_sel),
    .num_o     (ratio_num),
    .den_o     (ratio_den)
  );

  pll_div_counter #(.LEN_W(DEN_W)) u_ref_div (
    .clk    (ref_clk),
    .rst_n  (rst_n),
    .len_i  (ratio_den),
    .pulse_o(ref_pulse)
  );

  pll_div_counter #(.LEN_W(NUM_W)) u_fb_div (
    .clk    (fb_clk),
    .rst_n  (rst_n),
    .len_i  (ratio_num),
    .pulse_o(fb_pulse)
  );

  AST_RESET_QUIET: assert property (@(posedge fb_clk)
    !rst_n |-> !fb_pulse); // R8
endmodule

// File: tb/tb_pll_ratio_div.sv
module tb_pll_ratio_div;
  logic       ref_clk = 1'b0;
  logic       fb_clk  = 1'b0;
  logic       rst_n   = 1'b0;
  logic [7:0] fb_code = '0;
  logic [5:0] ref_code = '0;
  logic       prog_sel = 1'b1;
  logic       ref_bypass = 1'b0;
  logic       mult_sel = 1'b0;
  logic       ref_pulse, fb_pulse;
  logic [9:0] ratio_num;
  logic [6:0] ratio_den;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 fb_clk = ~fb_clk;
  initial begin
    #2;
    forever #4 ref_clk = ~ref_clk;
  end

  pll_ratio_div dut (
    .ref_clk(ref_clk), .fb_clk(fb_clk), .rst_n(rst_n),
    .fb_code(fb_code), .ref_code(ref_code), .prog_sel(prog_sel),
    .ref_bypass(ref_bypass), .mult_sel(mult_sel),
    .ref_pulse(ref_pulse), .fb_pulse(fb_pulse),
    .ratio_num(ratio_num), .ratio_den(ratio_den)
  );

  typedef struct packed {
    logic       prog;
    logic       byp;
    logic       msel;
    logic [7:0] fbc;
    logic [5:0] rfc;
    logic [9:0] exp_num;
    logic [6:0] exp_den;
  } vec_t;

  localparam int NVEC = 7;
  localparam vec_t VECS [NVEC] = '{
    '{1'b1, 1'b0, 1'b0, 8'd0,   6'd0,  10'd6,   7'd2},
    '{1'b1, 1'b0, 1'b0, 8'd255, 6'd63, 10'd516, 7'd65},
    '{1'b1, 1'b0, 1'b1, 8'd13,  6'd5,  10'd32,  7'd7},
    '{1'b1, 1'b1, 1'b0, 8'd7,   6'd40, 10'd20,  7'd1},
    '{1'b0, 1'b0, 1'b0, 8'd200, 6'd30, 10'd16,  7'd1},
    '{1'b0, 1'b1, 1'b1, 8'd3,   6'd9,  10'd8,   7'd1},
    '{1'b0, 1'b0, 1'b1, 8'd99,  6'd50, 10'd8,   7'd1}
  };

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic fb_gap(output int gap);
    int guard = 0;
    while (!fb_pulse && guard < 2000) begin @(negedge fb_clk); guard++; end
    gap = 0;
    do begin @(negedge fb_clk); gap++; end while (!fb_pulse && gap < 2000);
  endtask

  task automatic ref_gap(output int gap);
    int guard = 0;
    while (!ref_pulse && guard < 2000) begin @(negedge ref_clk); guard++; end
    gap = 0;
    do begin @(negedge ref_clk); gap++; end while (!ref_pulse && gap < 2000);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge fb_clk);
    errors++;
    $display("FAIL R5 watchdog expired actual=hung expected=done");
    finish_run();
  end

  initial begin
    int g, k;
    // R8: reset state and first-pulse latency (fb length 6, ref length 2)
    repeat (3) @(negedge fb_clk);
    check("R8", "fb_pulse in reset", int'(fb_pulse), 0);
    check("R8", "ref_pulse in reset", int'(ref_pulse), 0);
    rst_n = 1'b1;
    k = 0;
    do begin @(negedge fb_clk); k++; end while (!fb_pulse && k < 100);
    check("R8", "fb first pulse edge", k, 7);

    rst_n = 1'b0;
    @(negedge ref_clk);
    rst_n = 1'b1;
    k = 0;
    do begin @(negedge ref_clk); k++; end while (!ref_pulse && k < 100);
    check("R8", "ref first pulse edge", k, 3);

    // Table walk: ratio ports and pulse periods
    for (int i = 0; i < NVEC; i++) begin
      @(negedge fb_clk);
      prog_sel   = VECS[i].prog;
      ref_bypass = VECS[i].byp;
      mult_sel   = VECS[i].msel;
      fb_code    = VECS[i].fbc;
      ref_code   = VECS[i].rfc;
      #1;
      check(VECS[i].prog ? "R1" : "R4", "ratio_num", int'(ratio_num), int'(VECS[i].exp_num));
      check(!VECS[i].prog ? "R4" : (VECS[i].byp ? "R3" : "R2"), "ratio_den",
            int'(ratio_den), int'(VECS[i].exp_den));
      fb_gap(g);
      fb_gap(g);
      check("R5", "fb period", g, int'(VECS[i].exp_num));
      ref_gap(g);
      ref_gap(g);
      check("R5", "ref period", g, int'(VECS[i].exp_den));
    end

    // R4: codes have no effect in pin mode
    prog_sel = 1'b0; mult_sel = 1'b0; fb_code = 8'd1; ref_bypass = 1'b0; ref_code = 6'd63;
    #1;
    check("R4", "ratio_num codes ignored", int'(ratio_num), 16);
    check("R4", "ratio_den codes ignored", int'(ratio_den), 1);

    // R7: reference length 1 pulses on every cycle
    prog_sel = 1'b1; ref_bypass = 1'b1;
    ref_gap(g);
    ref_gap(g);
    k = 0;
    for (int j = 0; j < 6; j++) begin @(negedge ref_clk); k += int'(ref_pulse); end
    check("R7", "ref pulse high cycles of 6", k, 6);

    // R6: change mid-period keeps the running period
    fb_code = 8'd0;
    fb_gap(g);
    fb_gap(g);
    check("R6", "fb period before change", g, 6);
    @(negedge fb_clk);
    @(negedge fb_clk);
    fb_code = 8'd1;
    k = 2;
    do begin @(negedge fb_clk); k++; end while (!fb_pulse && k < 2000);
    check("R6", "period in progress keeps old length", k, 6);
    g = 0;
    do begin @(negedge fb_clk); g++; end while (!fb_pulse && g < 2000);
    check("R6", "next period uses new length", g, 8);

    finish_run();
  end
endmodule